// File: doc/BRIEF.md
# Exception Entry Bus Sequencer

This block runs the bus cycles that move a 16-bit processor core from normal execution into an exception handler. It handles reset, abort, non-maskable interrupt, maskable interrupt and the two software traps (break and coprocessor). For each one it stacks the return state, fetches a 16-bit vector from bank zero and hands the vector back as the new program counter. The core supplies the current program counter, program bank, status byte, stack pointer and emulation flag when it raises the request. The sequencer owns the bus until the jump completes.

The request enters on a valid/ready handshake. `req_ready` is high only while the sequencer is idle. A request held with `req_valid` while busy stays pending at the port and is neither queued nor lost. The bus side has no back-pressure: every active cycle lasts exactly one clock, and read data is taken on the clock edge that ends the cycle. The completion pulse `done` cannot be stalled, so the core must take `new_pc` in that cycle. Abort, NMI and IRQ also arrive as plain level lines on `late_req`. These are consulted once, at the point where the vector is chosen, so that a more urgent event can redirect an entry already in progress.

Top module: `exc_entry_seq`

## Requirements
- R1: `req_ready` is high exactly when the block is idle (no bus cycle, no `done`). A request is taken on a clock edge with `req_valid` and `req_ready` both high. `req_kind` codes are 0 reset, 1 abort, 2 NMI, 3 IRQ, 4 break, 5 coprocessor. An accepted code 6 or 7 starts nothing.
- R2: Reset, abort, NMI and IRQ begin with two internal cycles (`bus_cyc` = 3), each presenting `{bank_in, pc_in}` on the address.
- R3: In native mode (`emu` = 0), four stack writes (`bus_cyc` = 2) follow in this order: bank, PC high, PC low, status. Each goes to address `{8'h00, sp}`, and the stack pointer is decremented by one after each push.
- R4: In emulation mode the bank push is skipped, which removes one cycle. The stack pointer's high byte is forced to 8'h01 and stays there, and the low byte wraps from 8'h00 to 8'hFF.
- R5: The vector is chosen in the cycle of the PC-low push. `late_req` bit 0 is abort, bit 1 is NMI and bit 2 is IRQ. If a set bit has higher priority than the entry in progress, its vector is used. Priority runs from highest to lowest in code order 0 to 5. Reset is never overridden.
- R6: The vector is read as the low byte at `{8'h00, V}` and then the high byte at `{8'h00, V+1}` (`bus_cyc` = 1). Native V: abort FFE8, NMI FFEA, IRQ FFEE, break FFE6, coprocessor FFE4. Emulation V: abort FFF8, NMI FFFA, IRQ and break FFFE, coprocessor FFF4. Reset uses FFFC in both modes.
- R7: Reset keeps the same cycle count and addresses as the other hardware entries, and the stack pointer still steps down, but every stack access is a read (`bus_cyc` = 1).
- R8: Break and coprocessor replace the two internal cycles with one read at `{bank_in, pc_in}`. The PC value that is stacked is `pc_in + 1`.
- R9: `done` is a one-cycle pulse in the cycle after the vector high-byte read. During that pulse `new_pc` is `{high byte, low byte}` as read, `bank_out` is 0 and `sp_out` holds the final stack pointer. `req_ready` rises in the next cycle.
- R10: Changes on `req_valid` and `req_kind` while busy do not affect the sequence in progress and start no extra sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Exception request valid |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| req_kind | input | 3 | Exception source code |
| emu | input | 1 | Emulation mode flag, sampled at acceptance |
| pc_in | input | 16 | Current program counter |
| bank_in | input | 8 | Current program bank |
| psr_in | input | 8 | Status byte to stack |
| sp_in | input | 16 | Current stack pointer |
| late_req | input | 3 | Level lines: abort, NMI, IRQ, for vector takeover |
| bus_cyc | output | 2 | 0 none, 1 read, 2 write, 3 internal |
| bus_addr | output | 24 | Bus address |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, taken at the end of a read cycle |
| done | output | 1 | One-cycle completion pulse |
| new_pc | output | 16 | Vector fetched, valid with done |
| bank_out | output | 8 | Working program bank, zero at done |
| sp_out | output | 16 | Working stack pointer |

## Verification
The hardest case to reach is the vector takeover. The redirecting line has to be present exactly when the PC-low push happens, and it must not change the stacking that came before. The bench raises the `late_req` line before accepting the entry and holds it through completion. It checks that the stack writes match a plain entry while the vector reads move to the other source's address. It also covers a lower-priority line that must not win and a hardware line that overrides a software trap. The busy-time requests and the invalid codes are caught because the monitor flags any bus cycle for which the scoreboard expects nothing.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

  localparam int KIND_W  = 3;
  localparam int N_LATE  = 3;

  localparam logic [KIND_W-1:0] K_RESET = 3'd0;
  localparam logic [KIND_W-1:0] K_ABORT = 3'd1;
  localparam logic [KIND_W-1:0] K_NMI   = 3'd2;
  localparam logic [KIND_W-1:0] K_IRQ   = 3'd3;
  localparam logic [KIND_W-1:0] K_BRK   = 3'd4;
  localparam logic [KIND_W-1:0] K_COP   = 3'd5;

  localparam logic [1:0] CYC_NONE  = 2'd0;
  localparam logic [1:0] CYC_READ  = 2'd1;
  localparam logic [1:0] CYC_WRITE = 2'd2;
  localparam logic [1:0] CYC_INT   = 2'd3;

  typedef enum logic [3:0] {
    ST_IDLE, ST_IO1, ST_IO2, ST_SIG, ST_PBANK, ST_PCHI, ST_PCLO,
    ST_PSR, ST_VLO, ST_VHI, ST_DONE
  } seq_state_e;

  function automatic logic kind_ok(input logic [KIND_W-1:0] k);
    return k <= K_COP;
  endfunction

  function automatic logic kind_is_sw(input logic [KIND_W-1:0] k);
    return (k == K_BRK) || (k == K_COP);
  endfunction

  function automatic logic [15:0] vector_of(input logic [KIND_W-1:0] k, input logic em);
    logic [15:0] v;
    case (k)
      K_RESET: v = 16'hFFFC;
      K_ABORT: v = em ? 16'hFFF8 : 16'hFFE8;
      K_NMI:   v = em ? 16'hFFFA : 16'hFFEA;
      K_IRQ:   v = em ? 16'hFFFE : 16'hFFEE;
      K_BRK:   v = em ? 16'hFFFE : 16'hFFE6;
      default: v = em ? 16'hFFF4 : 16'hFFE4;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/exc_sp_unit.sv
module exc_sp_unit #(
  parameter int SP_W = 16,
  parameter int PAGE_W = 8,
  parameter logic [SP_W-PAGE_W-1:0] EMU_PAGE = 8'h01
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [SP_W-1:0] load_val,
  input  logic            emu,
  input  logic            step,
  output logic [SP_W-1:0] sp
);
  localparam int HI_W = SP_W - PAGE_W;

  logic [SP_W-1:0] dec_full;
  logic [PAGE_W-1:0] dec_page;

  assign dec_full = sp - 1'b1;
  assign dec_page = sp[PAGE_W-1:0] - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp <= '0;
    end else if (load) begin
      sp <= emu ? {EMU_PAGE, load_val[PAGE_W-1:0]} : load_val;
    end else if (step) begin
      sp <= emu ? {EMU_PAGE, dec_page} : dec_full;
    end
  end

  logic [HI_W-1:0] unused_hi;
  assign unused_hi = load_val[SP_W-1:PAGE_W];
endmodule

// File: rtl/exc_vec_select.sv
module exc_vec_select
  import exc_seq_pkg::*;
(
  input  logic [KIND_W-1:0] cur_kind,
  input  logic [N_LATE-1:0] late_req,
  input  logic              emu,
  output logic [KIND_W-1:0] sel_kind,
  output logic [15:0]       sel_vec
);
  always_comb begin
    sel_kind = cur_kind;
    if (cur_kind != K_RESET) begin
      for (int i = N_LATE - 1; i >= 0; i--) begin
        if (late_req[i] && (KIND_W'(i + 1) < cur_kind)) sel_kind = KIND_W'(i + 1);
      end
    end
  end

  assign sel_vec = vector_of(sel_kind, emu);
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_seq_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int BANK_W = 8,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [KIND_W-1:0]        req_kind,
  input  logic                     emu,
  input  logic [PC_W-1:0]          pc_in,
  input  logic [BANK_W-1:0]        bank_in,
  input  logic [DATA_W-1:0]        psr_in,
  input  logic [PC_W-1:0]          sp_in,
  input  logic [N_LATE-1:0]        late_req,
  output logic [1:0]               bus_cyc,
  output logic [BANK_W+PC_W-1:0]   bus_addr,
  output logic [DATA_W-1:0]        bus_wdata,
  input  logic [DATA_W-1:0]        bus_rdata,
  output logic                     done,
  output logic [PC_W-1:0]          new_pc,
  output logic [BANK_W-1:0]        bank_out,
  output logic [PC_W-1:0]          sp_out
);
  localparam int ADDR_W = BANK_W + PC_W;
  localparam logic [BANK_W-1:0] ZERO_BANK = '0;

  seq_state_e        state, state_nx;
  logic [KIND_W-1:0] kind_r;
  logic              emu_r;
  logic [PC_W-1:0]   pc_r;
  logic [BANK_W-1:0] bank_r;
  logic [DATA_W-1:0] psr_r;
  logic [15:0]       vec_r;
  logic [DATA_W-1:0] vlo_r;
  logic [PC_W-1:0]   newpc_r;

  logic              accept;
  logic              stack_cyc;
  logic [KIND_W-1:0] sel_kind;
  logic [15:0]       sel_vec;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready && kind_ok(req_kind);
  assign stack_cyc = (state == ST_PBANK) || (state == ST_PCHI) ||
                     (state == ST_PCLO)  || (state == ST_PSR);

  exc_sp_unit #(.SP_W(PC_W), .PAGE_W(DATA_W)) u_sp (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (sp_in),
    .emu      (accept ? emu : emu_r),
    .step     (stack_cyc),
    .sp       (sp_out)
  );

  exc_vec_select u_vsel (
    .cur_kind (kind_r),
    .late_req (late_req),
    .emu      (emu_r),
    .sel_kind (sel_kind),
    .sel_vec  (sel_vec)
  );

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE:  if (accept) state_nx = kind_is_sw(req_kind) ? ST_SIG : ST_IO1;
      ST_IO1:   state_nx = ST_IO2;
      ST_IO2,
      ST_SIG:   state_nx = emu_r ? ST_PCHI : ST_PBANK;
      ST_PBANK: state_nx = ST_PCHI;
      ST_PCHI:  state_nx = ST_PCLO;
      ST_PCLO:  state_nx = ST_PSR;
      ST_PSR:   state_nx = ST_VLO;
      ST_VLO:   state_nx = ST_VHI;
      ST_VHI:   state_nx = ST_DONE;
      ST_DONE:  state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      kind_r  <= K_RESET;
      emu_r   <= 1'b0;
      pc_r    <= '0;
      bank_r  <= '0;
      psr_r   <= '0;
      vec_r   <= '0;
      vlo_r   <= '0;
      newpc_r <= '0;
    end else begin
      state <= state_nx;
      if (accept) begin
        kind_r <= req_kind;
        emu_r  <= emu;
        pc_r   <= pc_in;
        bank_r <= bank_in;
        psr_r  <= psr_in;
      end
      if (state == ST_SIG) pc_r <= pc_r + 1'b1;
      if (state == ST_PCLO) begin
        kind_r <= sel_kind;
        vec_r  <= sel_vec;
      end
      if (state == ST_VLO) vlo_r <= bus_rdata;
      if (state == ST_VHI) begin
        newpc_r <= {bus_rdata, vlo_r};
        bank_r  <= ZERO_BANK;
      end
    end
  end

  always_comb begin
    bus_cyc   = CYC_NONE;
    bus_addr  = '0;
    bus_wdata = '0;
    case (state)
      ST_IO1, ST_IO2: begin
        bus_cyc  = CYC_INT;
        bus_addr = {bank_r, pc_r};
      end
      ST_SIG: begin
        bus_cyc  = CYC_READ;
        bus_addr = {bank_r, pc_r};
      end
      ST_PBANK, ST_PCHI, ST_PCLO, ST_PSR: begin
        bus_cyc  = (kind_r == K_RESET) ? CYC_READ : CYC_WRITE;
        bus_addr = {ZERO_BANK, sp_out};
        case (state)
          ST_PBANK: bus_wdata = bank_r;
          ST_PCHI:  bus_wdata = pc_r[PC_W-1:DATA_W];
          ST_PCLO:  bus_wdata = pc_r[DATA_W-1:0];
          default:  bus_wdata = psr_r;
        endcase
      end
      ST_VLO: begin
        bus_cyc  = CYC_READ;
        bus_addr = ADDR_W'(vec_r);
      end
      ST_VHI: begin
        bus_cyc  = CYC_READ;
        bus_addr = ADDR_W'(vec_r + 16'd1);
      end
      default: ;
    endcase
  end

  assign done     = (state == ST_DONE);
  assign new_pc   = newpc_r;
  assign bank_out = bank_r;
endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic [1:0]  bus_cyc,
  input logic [23:0] bus_addr,
  input logic        done,
  input logic [7:0]  bank_out,
  input logic [15:0] sp_out
);
  // R1
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (bus_cyc == 2'd0) && !done);

  // R3
  stack_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc == 2'd2) |-> (bus_addr[23:16] == 8'h00));

  // R3
  sp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc == 2'd2) |=> (sp_out[7:0] == $past(sp_out[7:0]) - 8'd1));

  // R6
  done_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(bus_cyc) == 2'd1));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && req_ready);

  // R9
  done_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (bank_out == 8'h00));
endmodule

bind exc_entry_seq exc_entry_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .bus_cyc   (bus_cyc),
  .bus_addr  (bus_addr),
  .done      (done),
  .bank_out  (bank_out),
  .sp_out    (sp_out)
);

// File: tb/sim_exc_entry_seq.sv
module sim_exc_entry_seq;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0;
  logic        req_ready;
  logic [2:0]  req_kind = 0;
  logic        emu = 0;
  logic [15:0] pc_in = 0;
  logic [7:0]  bank_in = 0;
  logic [7:0]  psr_in = 0;
  logic [15:0] sp_in = 0;
  logic [2:0]  late_req = 0;
  logic [1:0]  bus_cyc;
  logic [23:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic        done;
  logic [15:0] new_pc;
  logic [7:0]  bank_out;
  logic [15:0] sp_out;

  int n_chk = 0;
  int n_fail = 0;

  logic [1:0]  q_cyc[$];
  logic [23:0] q_addr[$];
  logic [7:0]  q_data[$];
  string       q_tag[$];
  logic [15:0] exp_pc;
  logic [15:0] exp_sp;
  string       exp_tag;

  always #4 clk = ~clk;

  assign bus_rdata = bus_addr[7:0] ^ 8'h5A;

  exc_entry_seq u0 (.*);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] vec_tbl(input logic [2:0] k, input logic em);
    case (k)
      3'd0: return 16'hFFFC;
      3'd1: return em ? 16'hFFF8 : 16'hFFE8;
      3'd2: return em ? 16'hFFFA : 16'hFFEA;
      3'd3: return em ? 16'hFFFE : 16'hFFEE;
      3'd4: return em ? 16'hFFFE : 16'hFFE6;
      default: return em ? 16'hFFF4 : 16'hFFE4;
    endcase
  endfunction

  task automatic push_exp(input logic [1:0] c, input logic [23:0] a, input logic [7:0] d, input string t);
    q_cyc.push_back(c); q_addr.push_back(a); q_data.push_back(d); q_tag.push_back(t);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && bus_cyc != 2'd0) begin
      if (q_cyc.size() == 0) begin
        check(0, "R10 unexpected bus cycle", {6'd0, bus_cyc, bus_addr}, 32'd0);
      end else begin
        logic [1:0] c; logic [23:0] a; logic [7:0] d; string t;
        c = q_cyc.pop_front(); a = q_addr.pop_front(); d = q_data.pop_front(); t = q_tag.pop_front();
        check(bus_cyc == c && bus_addr == a, t, {6'd0, bus_cyc, bus_addr}, {6'd0, c, a});
        if (c == 2'd2) check(bus_wdata == d, {t, " data"}, {24'd0, bus_wdata}, {24'd0, d});
      end
    end
    if (rst_n && done) begin
      check(new_pc == exp_pc, {exp_tag, " R9 new_pc"}, {16'd0, new_pc}, {16'd0, exp_pc});
      check(bank_out == 8'h00, "R9 bank cleared", {24'd0, bank_out}, 32'd0);
      check(sp_out == exp_sp, {exp_tag, " R4 final sp"}, {16'd0, sp_out}, {16'd0, exp_sp});
      check(q_cyc.size() == 0, "R9 sequence complete", q_cyc.size(), 32'd0);
    end
  end

  task automatic run_exc(input logic [2:0] k, input logic em, input logic [15:0] pc,
                         input logic [7:0] bk, input logic [7:0] ps, input logic [15:0] sp,
                         input logic [2:0] late, input bit poke_busy, input string tag);
    logic [15:0] s, pcs, v;
    logic [2:0]  ek;
    logic [1:0]  sc;
    s   = em ? {8'h01, sp[7:0]} : sp;
    pcs = pc;
    if (k == 3'd4 || k == 3'd5) begin
      push_exp(2'd1, {bk, pc}, 8'h00, {tag, " R8 signature read"});
      pcs = pc + 16'd1;
    end else begin
      push_exp(2'd3, {bk, pc}, 8'h00, {tag, " R2 idle 1"});
      push_exp(2'd3, {bk, pc}, 8'h00, {tag, " R2 idle 2"});
    end
    sc = (k == 3'd0) ? 2'd1 : 2'd2;
    if (!em) begin
      push_exp(sc, {8'h00, s}, bk, {tag, " R3 bank push"});
      s = s - 16'd1;
    end
    push_exp(sc, {8'h00, s}, pcs[15:8], {tag, " R3 pc hi push"});
    s = em ? {8'h01, s[7:0] - 8'd1} : s - 16'd1;
    push_exp(sc, {8'h00, s}, pcs[7:0], {tag, " R3 pc lo push"});
    s = em ? {8'h01, s[7:0] - 8'd1} : s - 16'd1;
    push_exp(sc, {8'h00, s}, ps, {tag, " R7 status push"});
    s = em ? {8'h01, s[7:0] - 8'd1} : s - 16'd1;
    ek = k;
    if (k != 3'd0) for (int i = 2; i >= 0; i--) if (late[i] && 3'(i + 1) < k) ek = 3'(i + 1);
    v = vec_tbl(ek, em);
    push_exp(2'd1, {8'h00, v}, 8'h00, {tag, " R6 vector lo R5"});
    push_exp(2'd1, {8'h00, v + 16'd1}, 8'h00, {tag, " R6 vector hi"});
    exp_pc = {(v[7:0] + 8'd1) ^ 8'h5A, v[7:0] ^ 8'h5A};
    exp_sp = s;
    exp_tag = tag;
    @(negedge clk);
    check(req_ready == 1'b1, {tag, " R1 ready when idle"}, {31'd0, req_ready}, 32'd1);
    req_kind = k; emu = em; pc_in = pc; bank_in = bk; psr_in = ps; sp_in = sp;
    late_req = late; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    check(req_ready == 1'b0, {tag, " R1 busy after accept"}, {31'd0, req_ready}, 32'd0);
    if (poke_busy) begin
      @(negedge clk);
      req_kind = 3'd2; req_valid = 1;
      repeat (3) @(negedge clk);
      req_valid = 0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    late_req = 0;
    check(req_ready == 1'b1, {tag, " R9 ready after done"}, {31'd0, req_ready}, 32'd1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(0, "watchdog", 32'd0, 32'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(req_ready == 1'b1 && bus_cyc == 2'd0 && done == 1'b0, "R1 reset state",
          {29'd0, req_ready, bus_cyc}, 32'd4);
    run_exc(3'd3, 1'b0, 16'h1234, 8'h7E, 8'hA5, 16'h01FF, 3'b000, 0, "irq native");
    run_exc(3'd2, 1'b1, 16'hC0DE, 8'h00, 8'h34, 16'h3F01, 3'b000, 0, "nmi emu wrap R4");
    run_exc(3'd1, 1'b0, 16'h4000, 8'h12, 8'h0F, 16'h2000, 3'b000, 0, "abort native");
    run_exc(3'd4, 1'b0, 16'h8000, 8'h05, 8'h30, 16'h1FF0, 3'b000, 1, "brk native busy R10");
    run_exc(3'd5, 1'b1, 16'hFFFF, 8'h00, 8'h22, 16'h01C0, 3'b000, 0, "cop emu R8");
    run_exc(3'd0, 1'b0, 16'h5555, 8'h33, 8'h44, 16'h0200, 3'b000, 0, "reset native R7");
    run_exc(3'd0, 1'b1, 16'h6666, 8'h00, 8'h00, 16'h0105, 3'b111, 0, "reset emu R7");
    run_exc(3'd3, 1'b0, 16'h0100, 8'h01, 8'h80, 16'h0300, 3'b010, 0, "irq takeover by nmi R5");
    run_exc(3'd2, 1'b0, 16'h0200, 8'h02, 8'h81, 16'h0400, 3'b100, 0, "nmi keeps vector R5");
    run_exc(3'd4, 1'b0, 16'h0300, 8'h03, 8'h82, 16'h0500, 3'b001, 0, "brk takeover by abort R5");
    // R1: invalid code starts nothing; monitor flags any bus cycle
    @(negedge clk);
    req_kind = 3'd6; req_valid = 1;
    repeat (2) @(negedge clk);
    req_kind = 3'd7;
    repeat (2) @(negedge clk);
    req_valid = 0;
    repeat (3) @(negedge clk);
    check(bus_cyc == 2'd0 && req_ready == 1'b1, "R1 invalid code ignored",
          {29'd0, req_ready, bus_cyc}, 32'd4);
    run_exc(3'd1, 1'b1, 16'hABCD, 8'h00, 8'h11, 16'h0180, 3'b000, 0, "abort emu after invalid");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule